// File: doc/BRIEF.md
# Interrupt Entry and Return Stack Sequencer

This block steps an 8-bit processor core through the bus traffic of taking an exception and of returning from one. When an enabled hardware request, a software trap or a return request is seen while the block is idle, it captures the register values the core presents. For an entry, it writes them byte by byte onto a stack that grows toward lower addresses, then reads a 16-bit handler address from a fixed table in the top sixteen bytes of memory. For a return, it reads the saved frame back. One `done` pulse marks the end of each sequence. The new program counter, condition codes, stack pointer and restored registers are then held on the outputs.

There are two entry frames. The fast request saves only the program counter and the condition codes, and clears the entire-state flag in the saved copy. Every other entry saves the full register set and sets that flag. The return sequence reads the condition-code byte first and uses its flag to decide whether to read back the full frame or only the program counter. Instruction decode and the arithmetic datapath belong to the core, not to this block.

Top module: `isq_top`

## Requirements
- R1: After reset is released, the block reads FFFE (high byte) and then FFFF (low byte) and loads the result into `pc_out`. It makes no write, leaves `cc_out` at 8'h50 (bits 6 and 4 set) and pulses `done`. While reset is held, `done` and `bus_we` are 0.
- R2: A full entry (every kind except the fast request) makes 12 writes. Each write first decrements the stack pointer taken from `s_in` and then writes at the new value. The bytes, in order, are: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. `s_out` ends at `s_in` minus 12.
- R3: The fast-request entry makes 3 writes: PC low, PC high, then CC. The stacked CC has bit 7 cleared. `s_out` ends at `s_in` minus 3.
- R4: The handler address is read high byte first from the even table address, then low byte from the next address. The even addresses are: NMI FFFC, fast request FFF6, normal request FFF8, trap 1 FFFA, trap 2 FFF4, trap 3 FFF2.
- R5: Every full entry stacks CC with bit 7 set; the fast entry stacks it with bit 7 clear. After the writes, NMI, fast request and trap 1 set bits 6 and 4 of `cc_out`, the normal request sets bit 4 only, and traps 2 and 3 leave both mask bits as stacked.
- R6: The fast request is ignored while `cc_in` bit 6 is set, and the normal request is ignored while `cc_in` bit 4 is set. An ignored request causes no bus write and no `done`.
- R7: When several requests are seen in one idle cycle, the block serves one of them. Priority runs NMI, fast request, normal request, trap 1, trap 2, trap 3, return.
- R8: A return reads CC first at `s_in`, then one byte per cycle at rising addresses. If bit 7 of the CC byte is set, it reads A, B, DP, X high, X low, Y high, Y low, U high, U low, PC high, PC low. The read values appear on the register outputs, and `s_out` ends at `s_in` plus 12.
- R9: If bit 7 of the CC byte read by a return is clear, only PC high and PC low follow, and `s_out` ends at `s_in` plus 3.
- R10: Requests are sampled only while the block is idle, so a request that comes and goes during a sequence is dropped. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts the reset-vector fetch |
| nmi_req | input | 1 | Non-maskable request |
| firq_req | input | 1 | Fast request, maskable by CC bit 6 |
| irq_req | input | 1 | Normal request, maskable by CC bit 4 |
| trap_req | input | 3 | Software traps 1, 2, 3 on bits 0, 1, 2 |
| ret_req | input | 1 | Return-from-exception request |
| pc_in | input | 16 | Program counter to save |
| u_in | input | 16 | User stack pointer to save |
| y_in | input | 16 | Index Y to save |
| x_in | input | 16 | Index X to save |
| dp_in | input | 8 | Direct page register to save |
| b_in | input | 8 | Accumulator B to save |
| a_in | input | 8 | Accumulator A to save |
| cc_in | input | 8 | Condition codes to save and masks to test |
| s_in | input | 16 | System stack pointer at start of sequence |
| rd_data | input | 8 | Memory read data, valid in the cycle of the address |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| pc_out | output | 16 | New program counter |
| cc_out | output | 8 | New condition codes |
| s_out | output | 16 | Final system stack pointer |
| a_out | output | 8 | Frame byte A (restored on a full return) |
| b_out | output | 8 | Frame byte B |
| dp_out | output | 8 | Frame byte DP |
| x_out | output | 16 | Frame X |
| y_out | output | 16 | Frame Y |
| u_out | output | 16 | Frame U |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two things can meet in one cycle here: several request lines active at the same idle edge, and a new request arriving while a sequence is still on the bus. The bench raises NMI with both maskable requests, the fast and normal requests together, and a normal request with a trap. In each case it judges the winner by the vector loaded and by the number of stack writes. It also pulses NMI in the middle of a normal-request entry and expects one `done`, the normal-request vector, and no further activity.

// File: rtl/isq_pkg.sv
package isq_pkg;
   typedef enum logic [2:0] {
      SRC_NONE, SRC_NMI, SRC_FIRQ, SRC_IRQ, SRC_TRAP1, SRC_TRAP2, SRC_TRAP3, SRC_RET
   } src_e;

   typedef enum logic [2:0] {ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_PULL} st_e;

   localparam int CC_ENTIRE = 7;
   localparam int CC_FMASK  = 6;
   localparam int CC_IMASK  = 4;
   localparam logic [7:0] CC_RESET = 8'h50;

   // Low nibble of the even table address for each source; NONE means reset.
   function automatic logic [3:0] vec_nibble(src_e s);
      case (s)
         SRC_NMI:   return 4'hC;
         SRC_FIRQ:  return 4'h6;
         SRC_IRQ:   return 4'h8;
         SRC_TRAP1: return 4'hA;
         SRC_TRAP2: return 4'h4;
         SRC_TRAP3: return 4'h2;
         default:   return 4'hE;
      endcase
   endfunction

   function automatic logic [7:0] apply_masks(src_e s, logic [7:0] c);
      logic [7:0] r;
      r = c;
      case (s)
         SRC_NMI, SRC_FIRQ, SRC_TRAP1: begin
            r[CC_FMASK] = 1'b1;
            r[CC_IMASK] = 1'b1;
         end
         SRC_IRQ: r[CC_IMASK] = 1'b1;
         default: r = c;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/isq_arbiter.sv
module isq_arbiter
   import isq_pkg::*;
#(
   parameter int TRAPS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             nmi,
   input  logic             firq,
   input  logic             irq,
   input  logic [TRAPS-1:0] trap,
   input  logic             ret,
   input  logic             f_mask,
   input  logic             i_mask,
   output src_e             grant
);
   if (TRAPS != 3) begin : g_bad_traps
      $error("isq_arbiter: TRAPS must be 3");
   end

   always_comb begin
      grant = SRC_NONE;
      if (enable) begin
         if (nmi)                grant = SRC_NMI;
         else if (firq && !f_mask) grant = SRC_FIRQ;
         else if (irq && !i_mask)  grant = SRC_IRQ;
         else if (trap[0])       grant = SRC_TRAP1;
         else if (trap[1])       grant = SRC_TRAP2;
         else if (trap[2])       grant = SRC_TRAP3;
         else if (ret)           grant = SRC_RET;
      end
   end

   a_r6_firq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == SRC_FIRQ) |-> !f_mask);
   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == SRC_IRQ) |-> !i_mask);
   a_r7_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && nmi) |-> (grant == SRC_NMI));
   a_r10_busy_blind: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (grant == SRC_NONE));
endmodule

// File: rtl/isq_frame.sv
module isq_frame #(
   parameter  int SLOTS = 12,
   parameter  int BW    = 8,
   localparam int IW    = $clog2(SLOTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [SLOTS-1:0][BW-1:0]  cap_bytes,
   input  logic                      wr_en,
   input  logic [IW-1:0]             wr_slot,
   input  logic [BW-1:0]             wr_byte,
   output logic [SLOTS-1:0][BW-1:0]  slots
);
   if (SLOTS < 3) begin : g_bad_slots
      $error("isq_frame: at least three slots are needed");
   end

   logic [BW-1:0] q [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[g] <= '0;
         else if (cap_en)
            q[g] <= cap_bytes[g];
         else if (wr_en && (wr_slot == IW'(g)))
            q[g] <= wr_byte;
      end
      assign slots[g] = q[g];
   end

   a_r8_no_mixed_load: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_en && wr_en));
endmodule

// File: rtl/isq_top.sv
module isq_top
   import isq_pkg::*;
#(
   parameter  int ADDR_W = 16,
   parameter  int BW     = 8,
   localparam int SLOTS  = 12,
   localparam int IW     = $clog2(SLOTS),
   localparam int LAST   = SLOTS - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_req,
   input  logic              firq_req,
   input  logic              irq_req,
   input  logic [2:0]        trap_req,
   input  logic              ret_req,
   input  logic [2*BW-1:0]   pc_in,
   input  logic [2*BW-1:0]   u_in,
   input  logic [2*BW-1:0]   y_in,
   input  logic [2*BW-1:0]   x_in,
   input  logic [BW-1:0]     dp_in,
   input  logic [BW-1:0]     b_in,
   input  logic [BW-1:0]     a_in,
   input  logic [BW-1:0]     cc_in,
   input  logic [ADDR_W-1:0] s_in,
   input  logic [BW-1:0]     rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BW-1:0]     bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   output logic [2*BW-1:0]   pc_out,
   output logic [BW-1:0]     cc_out,
   output logic [ADDR_W-1:0] s_out,
   output logic [BW-1:0]     a_out,
   output logic [BW-1:0]     b_out,
   output logic [BW-1:0]     dp_out,
   output logic [2*BW-1:0]   x_out,
   output logic [2*BW-1:0]   y_out,
   output logic [2*BW-1:0]   u_out,
   output logic              done
);
   if (BW != 8 || ADDR_W != 2 * BW) begin : g_bad_width
      $error("isq_top: byte width 8 and a two-byte address are required");
   end

   st_e                      st_q;
   src_e                     src_q, grant;
   logic [IW-1:0]            idx_q;
   logic [ADDR_W-1:0]        sp_q, vec_addr;
   logic                     fast_q;
   logic [BW-1:0]            vhi_q;
   logic [SLOTS-1:0][BW-1:0] cap_bytes, frame;
   logic                     cap_en, pull_wr;
   logic [IW-1:0]            pull_slot;
   logic [BW-1:0]            cc_stacked;

   isq_arbiter #(.TRAPS(3)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (st_q == ST_IDLE),
      .nmi    (nmi_req),
      .firq   (firq_req),
      .irq    (irq_req),
      .trap   (trap_req),
      .ret    (ret_req),
      .f_mask (cc_in[CC_FMASK]),
      .i_mask (cc_in[CC_IMASK]),
      .grant  (grant)
   );

   always_comb begin
      cc_stacked = cc_in;
      cc_stacked[CC_ENTIRE] = (grant != SRC_FIRQ);
      cap_bytes = {cc_stacked, a_in, b_in, dp_in, x_in, y_in, u_in, pc_in};
   end

   assign cap_en    = (grant != SRC_NONE) && (grant != SRC_RET);
   assign pull_wr   = (st_q == ST_PULL);
   assign pull_slot = IW'(LAST) - idx_q;

   isq_frame #(.SLOTS(SLOTS), .BW(BW)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .cap_bytes (cap_bytes),
      .wr_en     (pull_wr),
      .wr_slot   (pull_slot),
      .wr_byte   (rd_data),
      .slots     (frame)
   );

   assign vec_addr = {{(ADDR_W-4){1'b1}}, vec_nibble(src_q)};

   always_comb begin
      bus_addr  = '0;
      bus_wdata = '0;
      bus_we    = 1'b0;
      bus_re    = 1'b0;
      case (st_q)
         ST_PUSH: begin
            bus_addr  = sp_q - 1'b1;
            bus_wdata = frame[idx_q];
            bus_we    = 1'b1;
         end
         ST_VHI: begin
            bus_addr = vec_addr;
            bus_re   = 1'b1;
         end
         ST_VLO: begin
            bus_addr = vec_addr | ADDR_W'(1);
            bus_re   = 1'b1;
         end
         ST_PULL: begin
            bus_addr = sp_q;
            bus_re   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_VHI;
         src_q  <= SRC_NONE;
         idx_q  <= '0;
         sp_q   <= '0;
         fast_q <= 1'b0;
         vhi_q  <= '0;
         pc_out <= '0;
         cc_out <= CC_RESET;
         s_out  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (grant != SRC_NONE) begin
                  sp_q   <= s_in;
                  src_q  <= grant;
                  idx_q  <= '0;
                  fast_q <= (grant == SRC_FIRQ);
                  st_q   <= (grant == SRC_RET) ? ST_PULL : ST_PUSH;
               end
            end
            ST_PUSH: begin
               sp_q <= sp_q - 1'b1;
               if (idx_q == IW'(LAST))
                  st_q <= ST_VHI;
               else if (fast_q && idx_q == IW'(1))
                  idx_q <= IW'(LAST);
               else
                  idx_q <= idx_q + 1'b1;
            end
            ST_VHI: begin
               vhi_q <= rd_data;
               st_q  <= ST_VLO;
            end
            ST_VLO: begin
               pc_out <= {vhi_q, rd_data};
               if (src_q != SRC_NONE) begin
                  cc_out <= apply_masks(src_q, frame[LAST]);
                  s_out  <= sp_q;
               end
               done <= 1'b1;
               st_q <= ST_IDLE;
            end
            ST_PULL: begin
               sp_q <= sp_q + 1'b1;
               if (idx_q == '0)
                  idx_q <= rd_data[CC_ENTIRE] ? IW'(1) : IW'(LAST - 1);
               else if (idx_q == IW'(LAST)) begin
                  pc_out <= {frame[1], rd_data};
                  cc_out <= frame[LAST];
                  s_out  <= sp_q + 1'b1;
                  done   <= 1'b1;
                  st_q   <= ST_IDLE;
               end else
                  idx_q <= idx_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign a_out  = frame[10];
   assign b_out  = frame[9];
   assign dp_out = frame[8];
   assign x_out  = {frame[7], frame[6]};
   assign y_out  = {frame[5], frame[4]};
   assign u_out  = {frame[3], frame[2]};

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));
   a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && $past(bus_we)) |-> (bus_addr == $past(bus_addr) - 1'b1));
   a_r8_pull_ascends: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PULL && $past(st_q) == ST_PULL) |-> (bus_addr == $past(bus_addr) + 1'b1));
   a_r4_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_VLO) |-> (bus_addr == ($past(bus_addr) | ADDR_W'(1))));
endmodule

// File: tb/tb_isq_top.sv
module tb_isq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_req = 0, firq_req = 0, irq_req = 0, ret_req = 0;
   logic [2:0]  trap_req = '0;
   logic [15:0] pc_in = 0, u_in = 0, y_in = 0, x_in = 0, s_in = 16'h0180;
   logic [7:0]  dp_in = 0, b_in = 0, a_in = 0, cc_in = 0;
   logic [7:0]  rd_data;
   logic [15:0] bus_addr, pc_out, s_out, x_out, y_out, u_out;
   logic [7:0]  bus_wdata, cc_out, a_out, b_out, dp_out;
   logic        bus_we, bus_re, done;

   int total = 0, bad = 0, cycles = 0;

   logic [7:0]  ram [256];
   logic [15:0] la [16];
   logic [7:0]  ld [16];
   int          nw = 0;
   logic        clr_log = 1'b0;

   always #2 clk = ~clk;

   isq_top dut (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .firq_req(firq_req), .irq_req(irq_req),
      .trap_req(trap_req), .ret_req(ret_req), .pc_in(pc_in), .u_in(u_in), .y_in(y_in),
      .x_in(x_in), .dp_in(dp_in), .b_in(b_in), .a_in(a_in), .cc_in(cc_in), .s_in(s_in),
      .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_re(bus_re), .pc_out(pc_out), .cc_out(cc_out), .s_out(s_out), .a_out(a_out),
      .b_out(b_out), .dp_out(dp_out), .x_out(x_out), .y_out(y_out), .u_out(u_out), .done(done)
   );

   // Memory: stack page 0x01xx in ram, handler table computed in FFF0..FFFF.
   always_comb begin
      if (bus_addr[15:4] == 12'hFFF)
         rd_data = bus_addr[0] ? {bus_addr[3:0], 4'h3} : {4'h8, bus_addr[3:0]};
      else if (bus_addr[15:8] == 8'h01)
         rd_data = ram[bus_addr[7:0]];
      else
         rd_data = 8'h00;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (clr_log)
         nw <= 0;
      else if (bus_we) begin
         if (nw < 16) begin
            la[nw] <= bus_addr;
            ld[nw] <= bus_wdata;
         end
         nw <= nw + 1;
         if (bus_addr[15:8] == 8'h01) ram[bus_addr[7:0]] <= bus_wdata;
      end
   end

   always @(negedge clk) begin
      if (cycles > 100000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d exp=<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic start_log();
      @(negedge clk); clr_log = 1'b1;
      @(negedge clk); clr_log = 1'b0;
   endtask

   // Waits for done; returns 1 if seen, then checks it lasts one cycle (R10).
   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; break; end
      end
      if (seen) begin
         @(negedge clk);
         check("R10 done width", {31'b0, done}, 32'h0);
      end
   endtask

   task automatic pulse(input logic nmi, input logic firq, input logic irq,
                        input logic [2:0] trap, input logic ret);
      nmi_req = nmi; firq_req = firq; irq_req = irq; trap_req = trap; ret_req = ret;
      @(negedge clk);
      nmi_req = 0; firq_req = 0; irq_req = 0; trap_req = '0; ret_req = 0;
   endtask

   task automatic load_regs();
      pc_in = 16'h1234; u_in = 16'h5566; y_in = 16'h7788; x_in = 16'h99AA;
      dp_in = 8'h3C; b_in = 8'h2B; a_in = 8'h1A; s_in = 16'h0180;
   endtask

   task automatic t_reset();
      bit seen;
      repeat (3) @(negedge clk);
      check("R1 reset done low", {31'b0, done}, 32'h0);
      check("R1 reset no write", {31'b0, bus_we}, 32'h0);
      check("R1 reset cc", {24'b0, cc_out}, 32'h50);
      rst_n = 1'b1;
      wait_done(seen);
      check("R1 reset done seen", {31'b0, seen}, 32'h1);
      check("R1 reset vector", {16'b0, pc_out}, 32'h8EF3);
      check("R1 reset cc after", {24'b0, cc_out}, 32'h50);
      check("R1 reset writes", nw, 0);
   endtask

   task automatic t_full_irq();
      bit seen;
      logic [7:0] exp_b [12];
      exp_b = '{8'h34, 8'h12, 8'h66, 8'h55, 8'h88, 8'h77, 8'hAA, 8'h99, 8'h3C, 8'h2B, 8'h1A, 8'h80};
      load_regs(); cc_in = 8'h00;
      start_log();
      pulse(0, 0, 1, 3'b000, 0);
      wait_done(seen);
      check("R2 irq writes", nw, 12);
      for (int k = 0; k < 12; k++) begin
         check("R2 push addr", {16'b0, la[k]}, 32'h017F - k);
         check("R2 push byte / R5 E set", {24'b0, ld[k]}, {24'b0, exp_b[k]});
      end
      check("R4 irq vector", {16'b0, pc_out}, 32'h8893);
      check("R5 irq cc", {24'b0, cc_out}, 32'h90);
      check("R2 irq s_out", {16'b0, s_out}, 32'h0174);
   endtask

   task automatic t_full_return();
      bit seen;
      pc_in = 0; u_in = 0; y_in = 0; x_in = 0; dp_in = 0; b_in = 0; a_in = 0;
      cc_in = 8'h00; s_in = 16'h0174;
      start_log();
      pulse(0, 0, 0, 3'b000, 1);
      wait_done(seen);
      check("R8 ret pc", {16'b0, pc_out}, 32'h1234);
      check("R8 ret cc", {24'b0, cc_out}, 32'h80);
      check("R8 ret a b dp", {8'b0, a_out, b_out, dp_out}, 32'h1A2B3C);
      check("R8 ret x", {16'b0, x_out}, 32'h99AA);
      check("R8 ret y u", {y_out, u_out}, 32'h77885566);
      check("R8 ret s_out", {16'b0, s_out}, 32'h0180);
      check("R8 ret no writes", nw, 0);
   endtask

   task automatic t_fast_entry_return();
      bit seen;
      load_regs(); pc_in = 16'hBEEF; cc_in = 8'h8F;
      start_log();
      pulse(0, 1, 0, 3'b000, 0);
      wait_done(seen);
      check("R3 firq writes", nw, 3);
      check("R3 firq bytes", {ld[0], ld[1], ld[2]}, 32'hEFBE0F);
      check("R3 firq addrs", {la[0], la[2]}, 32'h017F017D);
      check("R4 firq vector", {16'b0, pc_out}, 32'h8673);
      check("R5 firq cc", {24'b0, cc_out}, 32'h5F);
      check("R3 firq s_out", {16'b0, s_out}, 32'h017D);
      cc_in = 8'h00; s_in = 16'h017D; pc_in = 0;
      start_log();
      pulse(0, 0, 0, 3'b000, 1);
      wait_done(seen);
      check("R9 short ret pc", {16'b0, pc_out}, 32'hBEEF);
      check("R9 short ret cc", {24'b0, cc_out}, 32'h0F);
      check("R9 short ret s_out", {16'b0, s_out}, 32'h0180);
   endtask

   task automatic t_traps_nmi();
      bit seen;
      load_regs(); cc_in = 8'h00;
      pulse(0, 0, 0, 3'b001, 0); wait_done(seen);
      check("R4 trap1 vector", {16'b0, pc_out}, 32'h8AB3);
      check("R5 trap1 cc", {24'b0, cc_out}, 32'hD0);
      pulse(0, 0, 0, 3'b010, 0); wait_done(seen);
      check("R4 trap2 vector", {16'b0, pc_out}, 32'h8453);
      check("R5 trap2 cc", {24'b0, cc_out}, 32'h80);
      pulse(0, 0, 0, 3'b100, 0); wait_done(seen);
      check("R4 trap3 vector", {16'b0, pc_out}, 32'h8233);
      check("R5 trap3 cc", {24'b0, cc_out}, 32'h80);
      pulse(1, 0, 0, 3'b000, 0); wait_done(seen);
      check("R4 nmi vector", {16'b0, pc_out}, 32'h8CD3);
      check("R5 nmi cc", {24'b0, cc_out}, 32'hD0);
   endtask

   task automatic t_priority();
      bit seen;
      load_regs(); cc_in = 8'h00;
      start_log();
      pulse(1, 1, 1, 3'b111, 1); wait_done(seen);
      check("R7 nmi beats all", {16'b0, pc_out}, 32'h8CD3);
      check("R7 single sequence", nw, 12);
      start_log();
      pulse(0, 1, 1, 3'b000, 0); wait_done(seen);
      check("R7 firq beats irq", {16'b0, pc_out}, 32'h8673);
      check("R7 firq frame", nw, 3);
      pulse(0, 0, 1, 3'b001, 0); wait_done(seen);
      check("R7 irq beats trap", {16'b0, pc_out}, 32'h8893);
      pulse(0, 0, 0, 3'b110, 0); wait_done(seen);
      check("R7 trap2 beats trap3", {16'b0, pc_out}, 32'h8453);
   endtask

   task automatic t_masked();
      bit seen;
      load_regs(); cc_in = 8'h50;
      start_log();
      firq_req = 1; irq_req = 1;
      wait_done(seen);
      check("R6 masked no done", {31'b0, seen}, 32'h0);
      check("R6 masked no write", nw, 0);
      cc_in = 8'h40;
      wait_done(seen);
      firq_req = 0; irq_req = 0;
      check("R6 irq unmasked taken", {16'b0, pc_out}, 32'h8893);
      repeat (30) @(negedge clk);
   endtask

   task automatic t_busy();
      bit seen;
      load_regs(); cc_in = 8'h00;
      start_log();
      pulse(0, 0, 1, 3'b000, 0);
      repeat (3) @(negedge clk);
      pulse(1, 0, 0, 3'b000, 0);
      wait_done(seen);
      check("R10 busy vector", {16'b0, pc_out}, 32'h8893);
      wait_done(seen);
      check("R10 dropped request", {31'b0, seen}, 32'h0);
      check("R10 dropped writes", nw, 12);
   endtask

   initial begin
      t_reset();
      t_full_irq();
      t_full_return();
      t_fast_entry_return();
      t_traps_nmi();
      t_priority();
      t_masked();
      t_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule